// File: doc/BRIEF.md
# Octave and Note Tone Generator

This block is a square-wave tone source for one sound channel, programmed by a host through three write strobes that share one data bus. One register holds a note divisor. A second holds a 3-bit octave code. A third holds a 3-bit volume. The pitch is set in two stages. First, the octave code chooses one of eight reference pulse trains, each at half the rate of the one below it, and a fixed divide-by-three stage counts those pulses. Second, the note counter counts the divide-by-three ticks and reloads from the note register. Each time it reaches zero, the tone output toggles.

The tone is ANDed with each volume bit. The three results go to an external binary-weighted mixer, where bit 0 carries weight 1, bit 1 weight 2 and bit 2 weight 4. The whole block runs in one clock domain and uses clock enables only. A host write is a single-cycle strobe and is always accepted. There is no handshake and no back-pressure: a strobe that is high at a clock edge loads the register at that edge.

Top module: `tone_gen_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `tone_o` and `vol_o` are 0. The note, octave and volume registers all clear to 0.
- R2: A `note_wr` strobe loads `wr_data[7:0]` as the note value N. The note counter then toggles `tone_o` once every N+1 ticks of the divide-by-three stage.
- R3: An `oct_wr` strobe loads only `wr_data[2:0]` as the octave code. Bits 7:3 are ignored.
- R4: With octave code k, the selected reference pulses once every 2^k clock cycles.
- R5: The note counter advances once per three reference pulses. In steady state, each level of `tone_o` therefore lasts exactly 3 * 2^k * (N+1) clock cycles.
- R6: `tone_o` is a square wave with a 50 percent duty cycle: the high and low phases have equal length.
- R7: When the volume register holds 0, all three `vol_o` lines stay 0 whatever the tone does.
- R8: `vol_o[i]` equals `tone_o` AND volume bit i, where the volume is `wr_data[2:0]` as loaded by a `vol_wr` strobe. The mixer weights are 1, 2 and 4 for i = 0, 1 and 2.
- R9: Writing a new note value does not disturb a count already in progress. The new value is used at the next reload, which happens at terminal count.
- R10: Strobes that arrive in the same cycle each load their own register from the same data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| note_wr | input | 1 | Strobe that loads the note divisor |
| oct_wr | input | 1 | Strobe that loads the octave code from bits 2:0 |
| vol_wr | input | 1 | Strobe that loads the volume from bits 2:0 |
| wr_data | input | 8 | Host write data |
| tone_o | output | 1 | Square-wave tone |
| vol_o | output | 3 | Tone gated by each volume bit (weights 1, 2, 4) |

## Verification
The assertions check the following on every cycle:
- the divide-by-three phase stays in range;
- the selected reference never pulses on two cycles in a row at a nonzero octave;
- the tone changes only after a tick;
- the note counter steps down by exactly one;
- the octave register loads only the low data bits;
- the gated outputs never exceed the volume register.

The exact half-period for a given octave and note, the equal length of the high and low phases, and a mid-count note change taking effect only at the next reload can only be shown by the bench. It measures toggle intervals over several settings and compares every cycle against a behavioural model.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int NOTE_W = 8;
  localparam int OCT_W  = 3;
  localparam int VOL_W  = 3;
  localparam int OCT_N  = 1 << OCT_W;
  localparam int PRE_W  = OCT_N - 1;
  typedef logic [NOTE_W-1:0] note_t;
  typedef logic [OCT_W-1:0]  oct_t;
  typedef logic [VOL_W-1:0]  vol_t;
endpackage

// File: rtl/tone_regs.sv
module tone_regs
  import tone_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  note_wr,
  input  logic  oct_wr,
  input  logic  vol_wr,
  input  note_t wr_data,
  output note_t note_q,
  output oct_t  oct_q,
  output vol_t  vol_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      note_q <= '0;
      oct_q  <= '0;
      vol_q  <= '0;
    end else begin
      if (note_wr) note_q <= wr_data;
      if (oct_wr)  oct_q  <= wr_data[OCT_W-1:0];
      if (vol_wr)  vol_q  <= wr_data[VOL_W-1:0];
    end
  end

  p_oct_low_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    oct_wr |=> oct_q == $past(wr_data[OCT_W-1:0]));
  p_note_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    note_wr |=> note_q == $past(wr_data));
  p_vol_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vol_wr |=> $stable(vol_q));
endmodule

// File: rtl/tone_prescaler.sv
module tone_prescaler
  import tone_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  oct_t oct_q,
  output logic ref_en
);
  logic [PRE_W-1:0] pre_q;
  logic [OCT_N-1:0] ref_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  for (genvar k = 0; k < OCT_N; k++) begin : g_ref
    if (k == 0) begin : g_base
      assign ref_vec[k] = 1'b1;
    end else begin : g_half
      assign ref_vec[k] = &pre_q[k-1:0];
    end
  end

  assign ref_en = ref_vec[oct_q];

  p_ref_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_en && oct_q != '0) |=> (!ref_en || oct_q != $past(oct_q)));
endmodule

// File: rtl/tone_div3.sv
module tone_div3 (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_en,
  output logic tick
);
  logic [1:0] ph_q;

  assign tick = ref_en && (ph_q == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ph_q <= 2'd0;
    else if (ref_en) ph_q <= (ph_q == 2'd2) ? 2'd0 : ph_q + 2'd1;
  end

  p_phase_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q != 2'd3);
  p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/tone_note_ctr.sv
module tone_note_ctr
  import tone_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  note_t note_q,
  output logic  tone_q
);
  note_t cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tone_q <= 1'b0;
    end else if (tick) begin
      if (cnt_q == '0) begin
        cnt_q  <= note_q;
        tone_q <= ~tone_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  p_tone_only_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tone_q));
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/tone_gen_top.sv
module tone_gen_top
  import tone_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             note_wr,
  input  logic             oct_wr,
  input  logic             vol_wr,
  input  logic [NOTE_W-1:0] wr_data,
  output logic             tone_o,
  output logic [VOL_W-1:0] vol_o
);
  note_t note_q;
  oct_t  oct_q;
  vol_t  vol_q;
  logic  ref_en;
  logic  tick;

  tone_regs u_regs (
    .clk(clk), .rst_n(rst_n), .note_wr(note_wr), .oct_wr(oct_wr),
    .vol_wr(vol_wr), .wr_data(wr_data),
    .note_q(note_q), .oct_q(oct_q), .vol_q(vol_q)
  );

  tone_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .oct_q(oct_q), .ref_en(ref_en)
  );

  tone_div3 u_div3 (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .tick(tick)
  );

  tone_note_ctr u_note (
    .clk(clk), .rst_n(rst_n), .tick(tick), .note_q(note_q), .tone_q(tone_o)
  );

  for (genvar i = 0; i < VOL_W; i++) begin : g_gate
    assign vol_o[i] = tone_o & vol_q[i];
  end

  p_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vol_q == '0) |-> (vol_o == '0));
  p_gate_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vol_o & ~vol_q) == '0);
endmodule

// File: tb/test_tone_gen_top.sv
module test_tone_gen_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       note_wr = 1'b0, oct_wr = 1'b0, vol_wr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tone_o;
  logic [2:0] vol_o;

  int tests = 0, fails = 0, cycles = 0;

  tone_gen_top i_tone_gen_top (
    .clk(clk), .rst_n(rst_n), .note_wr(note_wr), .oct_wr(oct_wr),
    .vol_wr(vol_wr), .wr_data(wr_data), .tone_o(tone_o), .vol_o(vol_o)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  int m_n, m_ph, m_cnt, m_note, m_oct, m_vol;
  bit m_tone;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_n = 0; m_ph = 0; m_cnt = 0; m_tone = 0;
      m_note = 0; m_oct = 0; m_vol = 0;
    end else begin
      bit refp, tk;
      int span;
      span = 1 << m_oct;
      refp = ((m_n % span) == span - 1);
      tk = 0;
      m_n++;
      if (refp) begin
        if (m_ph == 2) begin m_ph = 0; tk = 1; end
        else m_ph++;
      end
      if (tk) begin
        if (m_cnt == 0) begin m_cnt = m_note; m_tone = !m_tone; end
        else m_cnt--;
      end
      if (note_wr) m_note = wr_data;
      if (oct_wr)  m_oct  = wr_data & 8'h07;
      if (vol_wr)  m_vol  = wr_data & 8'h07;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // compare against model every cycle (R2 R5 R8 R10 model)
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(tone_o == m_tone, "R2/R5 model tone", tone_o, m_tone);
      check(vol_o == ({3{m_tone}} & m_vol[2:0]), "R8 model vol", vol_o,
            {3{m_tone}} & m_vol[2:0]);
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(input bit n, input bit o, input bit v, input logic [7:0] d);
    @(negedge clk);
    note_wr = n; oct_wr = o; vol_wr = v; wr_data = d;
    @(negedge clk);
    note_wr = 0; oct_wr = 0; vol_wr = 0; wr_data = '0;
  endtask

  task automatic next_toggle(output int len);
    logic last;
    last = tone_o;
    len = 0;
    do begin
      @(negedge clk);
      len++;
    end while (tone_o == last && len < 40000);
  endtask

  task automatic period_check(input int exp, input string req);
    int a, b;
    next_toggle(a);
    next_toggle(a);
    next_toggle(b);
    check(a == exp, req, a, exp);
    check(b == exp, req, b, exp);
    check(a == b, "R6 duty", a, b);
  endtask

  initial begin
    int len;
    repeat (3) @(negedge clk);
    check(tone_o == 0 && vol_o == 0, "R1 reset in", {tone_o, vol_o}, 0);
    rst_n = 1;
    @(negedge clk);
    check(tone_o == 0 && vol_o == 0, "R1 after release", {tone_o, vol_o}, 0);

    // R2 R5: octave 0, note 2 -> 3*1*3
    wr(1, 0, 0, 8'd2);
    wr(0, 0, 1, 8'd7);
    period_check(9, "R2 half period oct0 note2");
    check(vol_o == {3{tone_o}}, "R8 full volume", vol_o, {3{tone_o}});

    // R4: octave 3, note 4 -> 3*8*5
    wr(0, 1, 0, 8'd3);
    wr(1, 0, 0, 8'd4);
    period_check(120, "R4 half period oct3 note4");

    // R3: high data bits ignored, 0xFA -> octave 2; note 1 -> 3*4*2
    wr(0, 1, 0, 8'hFA);
    wr(1, 0, 0, 8'd1);
    period_check(24, "R3 octave low bits only");

    // R7: volume zero silences
    wr(0, 0, 1, 8'd0);
    begin
      int hits = 0;
      int toggles = 0;
      logic lt;
      lt = tone_o;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (vol_o != 0) hits++;
        if (tone_o != lt) toggles++;
        lt = tone_o;
      end
      check(hits == 0, "R7 silent outputs", hits, 0);
      check(toggles > 0, "R7 tone still running", toggles, 1);
    end

    // R8: volume 5 gates bits 0 and 2 only (weights 1 and 4)
    wr(0, 0, 1, 8'hF5);
    next_toggle(len);
    if (tone_o == 0) next_toggle(len);
    @(negedge clk);
    check(vol_o == 3'b101, "R8 weighted gate high", vol_o, 5);
    next_toggle(len);
    @(negedge clk);
    check(vol_o == 3'b000, "R8 weighted gate low", vol_o, 0);

    // R9: note change mid-count applies at next reload
    wr(0, 1, 0, 8'd0);
    wr(1, 0, 0, 8'd9);
    next_toggle(len);
    next_toggle(len);
    repeat (3) @(negedge clk);
    note_wr = 1; wr_data = 8'd0;
    @(negedge clk);
    note_wr = 0; wr_data = '0;
    next_toggle(len);
    check(len + 4 == 30, "R9 count undisturbed", len + 4, 30);
    next_toggle(len);
    check(len == 3, "R9 new note after reload", len, 3);

    // R10: simultaneous strobes: note 3, octave 3, volume 3 -> 3*8*4
    wr(1, 1, 1, 8'd3);
    period_check(96, "R10 joint write period");
    check((vol_o & 3'b100) == 0, "R10 joint volume", vol_o, {tone_o, tone_o} & 3);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule